// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a single-channel countdown timer that sits on a plain 32-bit memory-mapped register port. Software writes a countdown length, then fires a one-shot or a repeating countdown by writing any nonzero value to the matching action register. On each expiry the timer raises a sticky pending flag. That flag drives the interrupt output until software acknowledges it.

All control comes from a nonzero write to the register that belongs to the action. A write of zero to an action register is ignored. The length register sets the first countdown and also the reload value for every later period in repeating mode. It is read live, so a new value takes effect at the next reload. The bus port has one cycle per access and no wait states. Reads are combinational from the current state.

Top module: `ivt_timer`

## Requirements
- R1: After reset, status (word offset 0) reads 0, the length register (offset 12) reads 0 and `irq_o` is low.
- R2: A write to offset 12 stores the countdown length, and a read of offset 12 returns it. Reads of the action offsets 4, 8, 16 and 20 return 0.
- R3: A nonzero write to offset 16 starts a one-shot countdown of N cycles, where N is the stored length. Status bit 0 (active) is 1 from the cycle after the write. Exactly N cycles after the write edge, status bit 1 (pending) becomes 1 and bit 0 becomes 0.
- R4: A nonzero write to offset 20 starts a repeating countdown. Expiries occur every N cycles, and active stays 1 across each expiry.
- R5: A nonzero write to offset 4 clears active in the next cycle and leaves pending unchanged. A zero write there changes nothing.
- R6: A nonzero write to offset 8 clears pending in the next cycle. A zero write there changes nothing.
- R7: When an expiry and a nonzero write to offset 8 fall on the same edge, pending is 1 afterwards.
- R8: A stored length of 0 counts as a length of 1.
- R9: `irq_o` always equals status bit 1.
- R10: A zero write to offset 16 or 20 does not start a countdown.
- R11: A nonzero start write while a countdown is running restarts it from the full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when no read is made |
| irq_o | output | 1 | Interrupt, high while an expiry is pending |

## Verification
A read returns data in the cycle it is issued. A register write or action write takes effect on the same edge, so it is visible to a read in the next cycle. An expiry becomes visible exactly N edges after the start edge. The bench issues every access at a falling edge and samples one nanosecond later. It counts falling edges from the start write to place each status read one cycle before the expiry and again on the expiry cycle. The scoreboard then pairs each read with the value worked out for that cycle, and for status reads it also checks the interrupt line against the pending bit.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   // word indices of the register slots (byte offset = index * 4)
   localparam int unsigned WIDX_STATUS   = 0;
   localparam int unsigned WIDX_CANCEL   = 1;
   localparam int unsigned WIDX_ACK      = 2;
   localparam int unsigned WIDX_LENGTH   = 3;
   localparam int unsigned WIDX_ONESHOT  = 4;
   localparam int unsigned WIDX_REPEAT   = 5;
   localparam int unsigned NUM_SLOTS     = 6;

   // status bit positions
   localparam int unsigned STAT_ACTIVE   = 0;
   localparam int unsigned STAT_PENDING  = 1;

   // decoded single-cycle commands
   typedef struct packed {
      logic start;     // nonzero write to either start slot
      logic repeat_md; // mode that goes with start
      logic cancel;
      logic ack;
      logic len_we;
   } ivt_cmd_t;

endpackage

// File: rtl/ivt_regdec.sv
module ivt_regdec
   import ivt_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned CNT_W        = 32,
   parameter bit          STRICT_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              active_i,
   input  logic              pending_i,
   output ivt_cmd_t          cmd_o,
   output logic [CNT_W-1:0]  length_o,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int unsigned WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] widx;
   logic              aligned;
   logic              wr_ok;
   logic              rd_ok;
   logic              nz;
   logic [CNT_W-1:0]  length_q;
   logic [DATA_W-1:0] len_ext;

   assign widx = bus_addr[ADDR_W-1:2];

   generate
      if (STRICT_ALIGN) begin : g_strict
         assign aligned = (bus_addr[1:0] == 2'b00);
      end else begin : g_loose
         logic unused_low;
         assign unused_low = ^bus_addr[1:0];
         assign aligned    = 1'b1;
      end
   endgenerate

   assign wr_ok = bus_sel &  bus_wr & aligned;
   assign rd_ok = bus_sel & ~bus_wr & aligned;
   assign nz    = |bus_wdata;

   always_comb begin
      cmd_o = '0;
      if (wr_ok) begin
         unique case (widx)
            WIDX_W'(WIDX_CANCEL):  cmd_o.cancel = nz;
            WIDX_W'(WIDX_ACK):     cmd_o.ack    = nz;
            WIDX_W'(WIDX_LENGTH):  cmd_o.len_we = 1'b1;
            WIDX_W'(WIDX_ONESHOT): cmd_o.start  = nz;
            WIDX_W'(WIDX_REPEAT): begin
               cmd_o.start     = nz;
               cmd_o.repeat_md = 1'b1;
            end
            default: cmd_o = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         length_q <= '0;
      end else if (cmd_o.len_we) begin
         length_q <= bus_wdata[CNT_W-1:0];
      end
   end

   assign length_o = length_q;

   generate
      if (CNT_W == DATA_W) begin : g_len_full
         assign len_ext = length_q;
      end else begin : g_len_ext
         logic unused_hi;
         assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];
         assign len_ext   = {{(DATA_W-CNT_W){1'b0}}, length_q};
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         if (widx == WIDX_W'(WIDX_STATUS)) begin
            bus_rdata[STAT_ACTIVE]  = active_i;
            bus_rdata[STAT_PENDING] = pending_i;
         end else if (widx == WIDX_W'(WIDX_LENGTH)) begin
            bus_rdata = len_ext;
         end
      end
   end

   // R2: action slots always read as zero
   assert_action_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && (widx == WIDX_W'(WIDX_CANCEL) || widx == WIDX_W'(WIDX_ACK) ||
                 widx == WIDX_W'(WIDX_ONESHOT) || widx == WIDX_W'(WIDX_REPEAT)))
      |-> (bus_rdata == '0));

   // R2: the stored length follows the last write to its slot
   assert_length_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o.len_we |=> (length_o == $past(bus_wdata[CNT_W-1:0])));

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             repeat_i,
   input  logic             cancel_i,
   input  logic [CNT_W-1:0] length_i,
   output logic             active_o,
   output logic             expire_o
);

   logic [CNT_W-1:0] count_q;
   logic             active_q;
   logic             repeat_q;
   logic [CNT_W-1:0] load_val;

   // a zero length runs for one cycle so the counter can never stall
   assign load_val = (length_i == '0) ? CNT_W'(1) : length_i;
   assign expire_o = active_q && (count_q == CNT_W'(1));
   assign active_o = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         active_q <= 1'b0;
         repeat_q <= 1'b0;
      end else if (start_i) begin
         count_q  <= load_val;
         active_q <= 1'b1;
         repeat_q <= repeat_i;
      end else if (cancel_i) begin
         active_q <= 1'b0;
      end else if (expire_o) begin
         if (repeat_q) begin
            count_q <= load_val;
         end else begin
            active_q <= 1'b0;
            count_q  <= '0;
         end
      end else if (active_q) begin
         count_q <= count_q - CNT_W'(1);
      end
   end

   // R3: a one-shot stops at its expiry
   assert_oneshot_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !repeat_q && !start_i) |=> !active_o);

   // R4: a repeating countdown stays active across expiry
   assert_repeat_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && repeat_q && !cancel_i) |=> active_o);

   // R8: a running counter never holds zero
   assert_never_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> (count_q != '0));

   // R5: cancel stops the countdown
   assert_cancel_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_i && !start_i) |=> !active_o);

   // R11: a start loads the full length
   assert_start_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (active_o && count_q != '0));

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic ack_i,
   output logic pending_o
);

   logic pending_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else if (expire_i) begin
         pending_q <= 1'b1;  // expiry beats a same-cycle acknowledge
      end else if (ack_i) begin
         pending_q <= 1'b0;
      end
   end

   assign pending_o = pending_q;

   // R7: expiry always leaves the flag set
   assert_expire_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |=> pending_o);

   // R6: acknowledge without expiry clears
   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !expire_i) |=> !pending_o);

   // R3: the flag only rises after an expiry
   assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending_o) |-> $past(expire_i));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned CNT_W        = 32,
   parameter bit          STRICT_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int unsigned MIN_ADDR_W = $clog2(NUM_SLOTS) + 2;

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_chk_addr
         $error("ADDR_W too small for the register slots");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_chk_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (DATA_W < 2) begin : g_chk_data
         $error("DATA_W must hold the status bits");
      end
   endgenerate

   ivt_cmd_t         cmd;
   logic [CNT_W-1:0] length;
   logic             active;
   logic             expire;
   logic             pending;

   ivt_regdec #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .STRICT_ALIGN(STRICT_ALIGN)
   ) u_regdec (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .active_i (active),
      .pending_i(pending),
      .cmd_o    (cmd),
      .length_o (length),
      .bus_rdata(bus_rdata)
   );

   ivt_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cmd.start),
      .repeat_i(cmd.repeat_md),
      .cancel_i(cmd.cancel),
      .length_i(length),
      .active_o(active),
      .expire_o(expire)
   );

   ivt_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire_i (expire),
      .ack_i    (cmd.ack),
      .pending_o(pending)
   );

   assign irq_o = pending;

   // R10: a zero write to a start slot does not start an idle timer
   assert_zero_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_wdata == '0 && !active) |=> !active);

   // R1: interrupt is low in the first cycle out of reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !irq_o);

endmodule

// File: tb/tb_ivt_timer.sv
module tb_ivt_timer;

   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #4 clk = ~clk;   // 125 MHz

   ivt_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   typedef struct {
      logic [AW-1:0] addr;
      logic [DW-1:0] exp;
      string         tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     sample_ev;

   // monitor: pops expected items and compares
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (bus_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: addr %0d rdata %0h expected %0h", it.tag, it.addr, bus_rdata, it.exp);
            end
            if (it.addr == 0) begin
               n_tests++;
               if (irq_o !== it.exp[1]) begin
                  n_fail++;
                  $display("FAIL R9 (%s): irq_o %0b expected %0b", it.tag, irq_o, it.exp[1]);
               end
            end
         end
      end
   end

   // all tasks are entered at a falling edge and return at the next one
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      sb_item_t it;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      ->sample_ev;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      #1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 200000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: cycles %0d expected < 200000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0,  0, "R1 status");
      rd(12, 0, "R1 length");

      // R2 length readback and action slots reading zero
      wr(12, 32'hA5A5_0007);
      rd(12, 32'hA5A5_0007, "R2 length readback");
      rd(4,  0, "R2 cancel slot");
      rd(8,  0, "R2 ack slot");
      rd(16, 0, "R2 oneshot slot");
      rd(20, 0, "R2 repeat slot");

      // R10 zero start writes
      wr(16, 0);
      rd(0, 0, "R10 zero oneshot");
      wr(20, 0);
      idle(3);
      rd(0, 0, "R10 zero repeat");

      // R3 one-shot N=5
      wr(12, 5);
      wr(16, 1);
      idle(4);
      rd(0, 1, "R3 before expiry");
      rd(0, 2, "R3 at expiry");
      idle(3);
      rd(0, 2, "R3 stays stopped");

      // R6 acknowledge
      wr(8, 0);
      rd(0, 2, "R6 zero ack ignored");
      wr(8, 32'h100);
      rd(0, 0, "R6 ack clears");

      // R8 zero length = one cycle
      wr(12, 0);
      wr(16, 1);
      rd(0, 1, "R8 before expiry");
      rd(0, 2, "R8 at expiry");
      wr(8, 1);

      // R4 repeating N=3
      wr(12, 3);
      wr(20, 7);
      idle(2);
      rd(0, 1, "R4 before first expiry");
      rd(0, 3, "R4 first expiry");
      wr(8, 1);
      rd(0, 1, "R4 after ack");
      rd(0, 3, "R4 second expiry");

      // R7 expiry and acknowledge on the same edge
      wr(8, 1);     // clear before the third expiry
      wr(8, 1);     // lands on the edge of the third expiry
      rd(0, 3, "R7 expiry wins");

      // R5 cancel with pending held
      wr(4, 0);
      rd(0, 3, "R5 zero cancel ignored");
      wr(4, 1);
      rd(0, 2, "R5 cancel keeps pending");
      idle(4);
      rd(0, 2, "R5 stays cancelled");
      wr(8, 1);

      // R11 restart while running, N=6
      wr(12, 6);
      wr(16, 1);
      idle(2);
      wr(16, 1);    // restart three edges after the first start
      idle(5);
      rd(0, 1, "R11 no expiry at old time");
      rd(0, 2, "R11 expiry from restart");

      idle(2);
      finish_run();
   end

endmodule